// File: doc/BRIEF.md
# Descriptor Ring Index and Watermark Unit

This block keeps the producer and consumer positions for two descriptor rings that a host shares with a copy engine. One ring carries work from host to engine (the source ring) and the other returns buffers (the destination ring). For each ring the host programs a write position and the engine pulses a strobe each time it takes one descriptor. Both positions wrap with an AND-mask taken from a programmable power-of-two ring size, and the number of pending entries is the masked difference between them.

For each ring, a packed threshold register holds a low and a high fill level. When the fill level crosses a threshold, the unit sets a sticky status bit. A host write that would move the write position past the read position is dropped and recorded as an overflow. The status bits are gated by an enable register and combined into one registered interrupt line. All registers sit behind a simple word-addressed write/read port that has a registered read path.

Top module: `ring_idx_unit`

## Requirements
- R1: After reset, both ring sizes read back as 2^IDX_W entries. All positions, thresholds, status bits and enable bits read back as zero, and `irq` is low.
- R2: A size write is stored as a number of entries, rounded down to a power of two. A value of 2^IDX_W or more gives 2^IDX_W, and a value of zero gives 1. The size register reads back the rounded value.
- R3: A size write forces both positions of that ring to zero.
- R4: The fill level is (write − read) AND (size − 1), and it may reach size − 1. A host write is accepted, masked to the ring size, when its resulting fill level is not below the current fill level.
- R5: A host write whose resulting fill level would be below the current fill level leaves the write position unchanged. It sets status bit 5 for the source ring or bit 6 for the destination ring.
- R6: A consume strobe on a non-empty ring advances the read position by one modulo the size and sets status bit 0. A strobe on an empty ring changes nothing.
- R7: In a threshold register, bits 31:16 hold the low level and bits 15:0 hold the high level. When the fill level goes from at most the high level to above it, the unit sets bit 1 (source) or bit 3 (destination).
- R8: When the fill level goes from at least the low level to below it, the unit sets bit 2 (source) or bit 4 (destination). A low level of zero never fires.
- R9: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it alone.
- R10: The enable register has the same bit layout as the status register. `irq` is the registered OR of status AND enable.
- R11: Word addresses are as follows. Source ring: 0 size, 1 write position, 2 read position (read-only), 3 thresholds. Destination ring: 4 to 7 in the same order. Status is at 8 and enable is at 9. All other addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| src_consume | input | 1 | Engine took one source descriptor |
| dst_consume | input | 1 | Engine took one destination descriptor |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the unit with IDX_W = 4, so the largest ring holds 16 entries. This makes the clamp of oversized size writes reachable. It also lets a wrapped write position fill the ring to size − 1 within a few register writes. The bench shrinks the source ring to 8 and then 4 entries, so masked wrap, the full-ring boundary and the overflow rejection all occur with small position values. It also drops a ring's size while that ring is full, which produces a low-threshold crossing.

// File: rtl/ring_pkg.sv
package ring_pkg;
  localparam int REG_AW = 4;
  localparam int MARK_W = 16;
  localparam int NSTAT  = 7;

  // per-ring register offsets (address bits 1:0), ring select on bits 3:2
  localparam logic [1:0] OFF_SIZE  = 2'd0;
  localparam logic [1:0] OFF_WIDX  = 2'd1;
  localparam logic [1:0] OFF_RIDX  = 2'd2;
  localparam logic [1:0] OFF_MARKS = 2'd3;

  localparam logic [REG_AW-1:0] A_STATUS = 4'd8;
  localparam logic [REG_AW-1:0] A_ENABLE = 4'd9;

  // status bit positions
  localparam int ST_DONE    = 0;
  localparam int ST_SRC_HI  = 1;
  localparam int ST_SRC_LO  = 2;
  localparam int ST_DST_HI  = 3;
  localparam int ST_DST_LO  = 4;
  localparam int ST_SRC_OVF = 5;
  localparam int ST_DST_OVF = 6;
endpackage

// File: rtl/ring_track.sv
module ring_track
  import ring_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_size,
  input  logic             wr_widx,
  input  logic             wr_marks,
  input  logic [31:0]      wdata,
  input  logic             consume,
  output logic [IDX_W-1:0] widx_o,
  output logic [IDX_W-1:0] ridx_o,
  output logic [IDX_W-1:0] mask_o,
  output logic [31:0]      marks_o,
  output logic             evt_hi,
  output logic             evt_lo,
  output logic             evt_ovf,
  output logic             evt_done
);
  logic [IDX_W-1:0] widx_q, ridx_q, mask_q, occ_q;
  logic [31:0]      marks_q;
  logic [IDX_W-1:0] occ, occ_new;
  logic             widx_ok, take;
  logic [MARK_W-1:0] lo_lvl, hi_lvl, occ_w, occ_qw;

  // largest power of two not above v, as a mask; clamp at 2^IDX_W
  function automatic logic [IDX_W-1:0] size_to_mask(input logic [31:0] v);
    logic [IDX_W:0] pw;
    pw = '0;
    size_to_mask = '0;
    if (|(v >> IDX_W)) size_to_mask = '1;
    else begin
      for (int i = 0; i < IDX_W; i++) begin
        if (v[i]) begin
          pw = (IDX_W+1)'(1) << i;
          size_to_mask = IDX_W'(pw - 1'b1);
        end
      end
    end
  endfunction

  always_comb begin
    occ     = (widx_q - ridx_q) & mask_q;
    occ_new = (wdata[IDX_W-1:0] - ridx_q) & mask_q;
    widx_ok = (occ_new >= occ);
    take    = consume && (occ != '0);
    lo_lvl  = marks_q[31:16];
    hi_lvl  = marks_q[15:0];
    occ_w   = MARK_W'(occ);
    occ_qw  = MARK_W'(occ_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      widx_q  <= '0;
      ridx_q  <= '0;
      mask_q  <= '1;
      marks_q <= '0;
      occ_q   <= '0;
    end else begin
      occ_q <= occ;
      if (wr_marks) marks_q <= wdata;
      if (wr_size) begin
        mask_q <= size_to_mask(wdata);
        widx_q <= '0;
        ridx_q <= '0;
      end else begin
        if (wr_widx && widx_ok) widx_q <= wdata[IDX_W-1:0] & mask_q;
        if (take) ridx_q <= (ridx_q + 1'b1) & mask_q;
      end
    end
  end

  assign evt_hi   = (occ_qw <= hi_lvl) && (occ_w > hi_lvl);
  assign evt_lo   = (occ_qw >= lo_lvl) && (occ_w < lo_lvl);
  assign evt_ovf  = wr_widx && !wr_size && !widx_ok;
  assign evt_done = take && !wr_size;
  assign widx_o   = widx_q;
  assign ridx_o   = ridx_q;
  assign mask_o   = mask_q;
  assign marks_o  = marks_q;
endmodule

// File: rtl/ring_irq.sv
module ring_irq #(
  parameter int NB = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_vec,
  input  logic          wr_status,
  input  logic          wr_enable,
  input  logic [NB-1:0] wdata,
  output logic [NB-1:0] status_o,
  output logic [NB-1:0] enable_o,
  output logic          irq_o
);
  logic [NB-1:0] st_q, en_q, clr;
  logic          irq_q;

  assign clr = wr_status ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= (st_q & ~clr) | set_vec;
      if (wr_enable) en_q <= wdata;
      irq_q <= |(st_q & en_q);
    end
  end

  assign status_o = st_q;
  assign enable_o = en_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/ring_idx_unit.sv
module ring_idx_unit
  import ring_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              src_consume,
  input  logic              dst_consume,
  output logic              irq
);
  localparam int NR = 2;

  logic [NR-1:0][IDX_W-1:0] widx_a, ridx_a, mask_a;
  logic [NR-1:0][31:0]      marks_a;
  logic [NR-1:0]            hi_v, lo_v, ovf_v, done_v, consume_v;
  logic [NSTAT-1:0]         set_vec, st_vec, en_vec;
  logic [31:0]              rd_n, rd_q;

  assign consume_v = {dst_consume, src_consume};

  for (genvar r = 0; r < NR; r++) begin : g_ring
    logic sel;
    assign sel = reg_wr && (reg_addr[3:2] == 2'(r));
    ring_track #(.IDX_W(IDX_W)) u_trk (
      .clk(clk), .rst(rst),
      .wr_size (sel && reg_addr[1:0] == OFF_SIZE),
      .wr_widx (sel && reg_addr[1:0] == OFF_WIDX),
      .wr_marks(sel && reg_addr[1:0] == OFF_MARKS),
      .wdata(reg_wdata), .consume(consume_v[r]),
      .widx_o(widx_a[r]), .ridx_o(ridx_a[r]), .mask_o(mask_a[r]),
      .marks_o(marks_a[r]),
      .evt_hi(hi_v[r]), .evt_lo(lo_v[r]), .evt_ovf(ovf_v[r]), .evt_done(done_v[r])
    );
  end

  always_comb begin
    set_vec             = '0;
    set_vec[ST_DONE]    = |done_v;
    set_vec[ST_SRC_HI]  = hi_v[0];
    set_vec[ST_SRC_LO]  = lo_v[0];
    set_vec[ST_DST_HI]  = hi_v[1];
    set_vec[ST_DST_LO]  = lo_v[1];
    set_vec[ST_SRC_OVF] = ovf_v[0];
    set_vec[ST_DST_OVF] = ovf_v[1];
  end

  ring_irq #(.NB(NSTAT)) u_irq (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .wr_status(reg_wr && reg_addr == A_STATUS),
    .wr_enable(reg_wr && reg_addr == A_ENABLE),
    .wdata(reg_wdata[NSTAT-1:0]),
    .status_o(st_vec), .enable_o(en_vec), .irq_o(irq)
  );

  always_comb begin
    rd_n = '0;
    if (!reg_addr[3]) begin
      case (reg_addr[1:0])
        OFF_SIZE:  rd_n = 32'(mask_a[reg_addr[2]]) + 32'd1;
        OFF_WIDX:  rd_n = 32'(widx_a[reg_addr[2]]);
        OFF_RIDX:  rd_n = 32'(ridx_a[reg_addr[2]]);
        default:   rd_n = marks_a[reg_addr[2]];
      endcase
    end else if (reg_addr == A_STATUS) rd_n = 32'(st_vec);
    else if (reg_addr == A_ENABLE)     rd_n = 32'(en_vec);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_n;
  end

  assign reg_rdata = rd_q;
endmodule

// File: rtl/ring_idx_chk.sv
module ring_idx_chk
  import ring_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   reg_wr,
  input logic [REG_AW-1:0]      reg_addr,
  input logic [31:0]            reg_wdata,
  input logic                   dst_consume,
  input logic                   irq,
  input logic [1:0][IDX_W-1:0]  widx_a,
  input logic [1:0][IDX_W-1:0]  ridx_a,
  input logic [1:0][IDX_W-1:0]  mask_a,
  input logic [NSTAT-1:0]       st_vec,
  input logic [NSTAT-1:0]       en_vec
);
  // R2: ring size is always a power of two
  p_size_pow2_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones({1'b0, mask_a[0]} + 1'b1) == 1) && ($countones({1'b0, mask_a[1]} + 1'b1) == 1));

  // R3: size write zeroes both positions
  p_size_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 4'd0) |=> (widx_a[0] == '0 && ridx_a[0] == '0));

  // R5: overflow flag rises only together with an unchanged write position
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(st_vec[ST_SRC_OVF]) |-> $stable(widx_a[0]));

  // R6: consume on an empty ring leaves the read position
  p_empty_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (dst_consume && widx_a[1] == ridx_a[1] && !(reg_wr && reg_addr == 4'd4)) |=> $stable(ridx_a[1]));

  // R9: a status bit falls only after a write of one to it
  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(st_vec[ST_DONE]) |-> $past(reg_wr && reg_addr == A_STATUS && reg_wdata[ST_DONE]));

  // R10: nothing enabled means no interrupt next cycle
  p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
    (en_vec == '0) |=> !irq);
endmodule

bind ring_idx_unit ring_idx_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .dst_consume(dst_consume), .irq(irq), .widx_a(widx_a), .ridx_a(ridx_a),
  .mask_a(mask_a), .st_vec(st_vec), .en_vec(en_vec)
);

// File: tb/ring_idx_unit_tb_top.sv
`timescale 1ns/1ps
module ring_idx_unit_tb_top;
  localparam int IDX_W = 4;
  localparam int NV    = 50;
  // {kind(2), req(4), addr(4), data(32), expected(32)}; kind 0 write, 1 read, 2 src consume, 3 dst consume
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 4'd2, 4'd0, 32'd12,         32'd0},          // R2 size 12 -> 8
    {2'd1, 4'd2, 4'd0, 32'd0,          32'd8},
    {2'd0, 4'd7, 4'd3, 32'h0002_0005,  32'd0},          // R7 low 2 high 5
    {2'd1, 4'd7, 4'd3, 32'd0,          32'h0002_0005},
    {2'd0, 4'd4, 4'd1, 32'd6,          32'd0},          // R4 fill 6
    {2'd1, 4'd4, 4'd1, 32'd0,          32'd6},
    {2'd1, 4'd7, 4'd8, 32'd0,          32'h02},         // R7 high crossing
    {2'd0, 4'd9, 4'd8, 32'h02,         32'd0},          // R9 clear
    {2'd1, 4'd9, 4'd8, 32'd0,          32'h00},
    {2'd2, 4'd6, 4'd0, 32'd0,          32'd0},          // R6 consume x5
    {2'd2, 4'd6, 4'd0, 32'd0,          32'd0},
    {2'd2, 4'd6, 4'd0, 32'd0,          32'd0},
    {2'd2, 4'd6, 4'd0, 32'd0,          32'd0},
    {2'd2, 4'd6, 4'd0, 32'd0,          32'd0},
    {2'd1, 4'd6, 4'd2, 32'd0,          32'd5},
    {2'd1, 4'd8, 4'd8, 32'd0,          32'h05},         // R8 low crossing
    {2'd0, 4'd4, 4'd1, 32'd4,          32'd0},          // R4 wrap to full (7)
    {2'd1, 4'd4, 4'd1, 32'd0,          32'd4},
    {2'd0, 4'd5, 4'd1, 32'd5,          32'd0},          // R5 passes read
    {2'd1, 4'd5, 4'd1, 32'd0,          32'd4},
    {2'd1, 4'd5, 4'd8, 32'd0,          32'h27},
    {2'd0, 4'd9, 4'd8, 32'h20,         32'd0},          // R9 partial clear
    {2'd1, 4'd9, 4'd8, 32'd0,          32'h07},
    {2'd0, 4'd9, 4'd8, 32'h7F,         32'd0},
    {2'd3, 4'd6, 4'd0, 32'd0,          32'd0},          // R6 empty consume
    {2'd1, 4'd6, 4'd6, 32'd0,          32'd0},
    {2'd1, 4'd6, 4'd8, 32'd0,          32'h00},
    {2'd0, 4'd2, 4'd4, 32'd100,        32'd0},          // R2 clamp
    {2'd1, 4'd2, 4'd4, 32'd0,          32'd16},
    {2'd0, 4'd2, 4'd4, 32'd0,          32'd0},          // R2 zero -> 1
    {2'd1, 4'd2, 4'd4, 32'd0,          32'd1},
    {2'd0, 4'd2, 4'd4, 32'd16,         32'd0},
    {2'd0, 4'd7, 4'd7, 32'h0000_0003,  32'd0},          // R7 dst high 3
    {2'd0, 4'd7, 4'd5, 32'd4,          32'd0},
    {2'd1, 4'd7, 4'd8, 32'd0,          32'h08},
    {2'd3, 4'd6, 4'd0, 32'd0,          32'd0},          // R6 dst consume
    {2'd1, 4'd6, 4'd6, 32'd0,          32'd1},
    {2'd1, 4'd6, 4'd8, 32'd0,          32'h09},
    {2'd0, 4'd3, 4'd0, 32'd4,          32'd0},          // R3 size write
    {2'd1, 4'd3, 4'd1, 32'd0,          32'd0},
    {2'd1, 4'd3, 4'd2, 32'd0,          32'd0},
    {2'd1, 4'd2, 4'd0, 32'd0,          32'd4},
    {2'd1, 4'd8, 4'd8, 32'd0,          32'h0D},         // R8 fill 7 -> 0
    {2'd0, 4'd9, 4'd8, 32'h7F,         32'd0},
    {2'd0, 4'd4, 4'd5, 32'd0,          32'd0},          // R4 dst fill 15
    {2'd1, 4'd4, 4'd5, 32'd0,          32'd0},
    {2'd0, 4'd5, 4'd5, 32'd1,          32'd0},          // R5 dst overflow
    {2'd1, 4'd5, 4'd5, 32'd0,          32'd0},
    {2'd1, 4'd5, 4'd8, 32'd0,          32'h48},
    {2'd1, 4'd11, 4'd12, 32'd0,        32'd0}           // R11 unmapped
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        src_consume = 1'b0;
  logic        dst_consume = 1'b0;
  logic        irq;
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ring_idx_unit #(.IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_consume(src_consume), .dst_consume(dst_consume), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    check(reg_rdata, exp, tag);
  endtask

  task automatic do_consume(input bit dst);
    if (dst) dst_consume = 1'b1; else src_consume = 1'b1;
    @(negedge clk);
    dst_consume = 1'b0; src_consume = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    do_rd(4'd0, 32'd16, "R1 src size");
    do_rd(4'd8, 32'd0, "R1 status");
    check({31'd0, irq}, 32'd0, "R1 irq");

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  k;
      logic [3:0]  rq, ad;
      logic [31:0] dt, ex;
      {k, rq, ad, dt, ex} = VEC[i];
      case (k)
        2'd0: do_wr(ad, dt);
        2'd1: do_rd(ad, ex, $sformatf("R%0d vector %0d", rq, i));
        2'd2: do_consume(1'b0);
        default: do_consume(1'b1);
      endcase
    end

    // R10 interrupt gating; status now holds 0x48
    do_wr(4'd9, 32'h40);
    check({31'd0, irq}, 32'd1, "R10 irq on overflow enable");
    do_rd(4'd9, 32'h40, "R10 enable readback");
    do_wr(4'd9, 32'h01);
    check({31'd0, irq}, 32'd0, "R10 irq masked");
    do_wr(4'd9, 32'h08);
    check({31'd0, irq}, 32'd1, "R10 irq dst high");
    do_wr(4'd8, 32'h08);
    check({31'd0, irq}, 32'd0, "R10 irq after clear");
    do_rd(4'd8, 32'h40, "R9 other bit kept");

    // R1 reset again from a busy state
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    do_rd(4'd0, 32'd16, "R1 src size after reset");
    do_rd(4'd4, 32'd16, "R1 dst size after reset");
    do_rd(4'd5, 32'd0, "R1 dst widx after reset");
    do_rd(4'd3, 32'd0, "R1 marks after reset");
    do_rd(4'd8, 32'd0, "R1 status after reset");
    do_rd(4'd9, 32'd0, "R1 enable after reset");
    check({31'd0, irq}, 32'd0, "R1 irq after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule